// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This block records which cache lines one hardware transaction has read and written, so that the transaction can be aborted when another agent touches those lines or when the lines no longer fit. It keeps a tag array laid out like an 8-way set-associative data cache. Each entry holds a tag, a valid bit, a read-set bit and a write-set bit. A transaction controller brackets each transaction with start, commit and abort strobes. Local loads and stores arrive on one access port, one per cycle. Coherence snoops from other agents arrive on a separate port, with a flag that tells a read from a write.

Membership is kept per 64-byte line. Address bits [11:6] select one of 64 sets, and bits [31:12] form the tag. A transactional access that misses takes the lowest-numbered way of its set that holds no transactional line. When every way already belongs to the transaction, the block raises a capacity abort. Software can suspend load tracking inside a transaction. Loads are then neither recorded nor allocated, but lines recorded earlier, and all stores, still count. Commit and abort empty both sets in one cycle. Abort also invalidates the lines the transaction wrote. Outside a transaction, accesses allocate nothing and snoops never abort.

Top module: `txn_set_tracker`

## Requirements
- R1: After reset, `conflict_abort` and `overflow_abort` are low, and no transaction is active.
- R2: Two addresses inside the same 64-byte line are one member of the set. A repeat access takes no extra way, and a snoop to any byte of a tracked line finds it.
- R3: During a transaction, eight distinct lines in one set (same addr[11:6], different addr[31:12]) raise no abort. A ninth raises `overflow_abort` for exactly one cycle, in the cycle after the access is sampled.
- R4: A write snoop (`snp_write`=1) to a line in the read set or the write set raises `conflict_abort` in the cycle after the snoop is sampled.
- R5: A read snoop (`snp_write`=0) raises `conflict_abort` only for a line in the write set. A read snoop to a line that is only in the read set is ignored.
- R6: While load tracking is suspended, loads are not added to the read set and allocate no way. A later write snoop to such a line does not abort, and such loads never cause a capacity abort.
- R7: While load tracking is suspended, lines tracked before the suspension still conflict when snooped, and stores are still tracked.
- R8: A resume command makes later loads tracked again.
- R9: Commit and abort clear every read and write bit in one cycle. A later transaction sees no conflict on the old lines and has all eight ways of each set free again.
- R10: Suspend and resume commands issued outside a transaction have no effect on the next transaction.
- R11: At most one abort pulse is issued per transaction. If a conflict and an overflow are detected in the same cycle, only `conflict_abort` rises. Later events are ignored until the next `txn_begin`.
- R12: Outside a transaction, accesses are not tracked, and snoops never raise an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| txn_begin | input | 1 | Transaction start strobe |
| txn_commit | input | 1 | Transaction commit strobe |
| txn_abort | input | 1 | Transaction abort strobe from the controller |
| trk_suspend | input | 1 | Suspend load tracking |
| trk_resume | input | 1 | Resume load tracking |
| acc_valid | input | 1 | Local access present |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Local access byte address |
| snp_valid | input | 1 | Remote snoop present |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_addr | input | 32 | Snoop byte address |
| conflict_abort | output | 1 | One-cycle pulse: a snoop hit the transaction's sets |
| overflow_abort | output | 1 | One-cycle pulse: a set ran out of ways |

## Verification
Both abort outputs are registered. An access or snoop sampled at rising edge k shows its abort from edge k until edge k+1, and commit, abort, begin, suspend and resume take effect for inputs sampled at edge k+1. Each bench task drives its inputs just after a falling edge, waits one rising edge, and then reads the outputs at the next falling edge. That is exactly the one-cycle window in which a pulse caused by that stimulus is visible. A second read one cycle later confirms that each pulse lasts only one cycle.

// File: rtl/txn_trk_pkg.sv
// Package: shared defaults and the abort-cause encoding of the set tracker.
// Assumes nothing beyond IEEE 1800-2017.
package txn_trk_pkg;

    localparam int DEF_ADDR_W = 32;
    localparam int DEF_OFF_W  = 6;
    localparam int DEF_IDX_W  = 6;
    localparam int DEF_WAYS   = 8;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_CONFLICT = 2'd1,
        CAUSE_OVERFLOW = 2'd2
    } cause_e;

endpackage

// File: rtl/trk_way_lookup.sv
// Module: trk_way_lookup
// Compares one tag against all ways of a set. Reports a hit and its way,
// plus the lowest way that holds no transactional line (invalid, or valid
// with neither set bit). Purely combinational. Assumes at most one valid
// way per tag, which the allocation rule guarantees.
module trk_way_lookup #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 20,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [TAG_W-1:0]            tag_in,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0]             way_rd,
    input  logic [WAYS-1:0]             way_wr,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic                        free_ok,
    output logic [WAY_W-1:0]            free_way
);

    // Scan from the top way down so that the lowest matching way wins.
    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        free_ok  = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_valid[w] && (way_tag[w] == tag_in)) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!way_valid[w] || !(way_rd[w] || way_wr[w])) begin
                free_ok  = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/trk_tag_array.sv
// Module: trk_tag_array
// Flop-based tag, valid, read-set and write-set storage with two read
// ports (access and snoop) and one update port. A bulk clear of all set
// bits takes priority over the update port, and can also invalidate the
// written lines. Assumes the caller never requests update and clear in
// the same cycle with meaning. Tags are not reset.
module trk_tag_array #(
    parameter int SETS  = 64,
    parameter int WAYS  = 8,
    parameter int TAG_W = 20,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            a_set,
    output logic [WAYS-1:0][TAG_W-1:0]  a_tag,
    output logic [WAYS-1:0]             a_valid,
    output logic [WAYS-1:0]             a_rd,
    output logic [WAYS-1:0]             a_wr,
    input  logic [IDX_W-1:0]            b_set,
    output logic [WAYS-1:0][TAG_W-1:0]  b_tag,
    output logic [WAYS-1:0]             b_valid,
    output logic [WAYS-1:0]             b_rd,
    output logic [WAYS-1:0]             b_wr,
    input  logic                        upd_en,
    input  logic                        upd_alloc,
    input  logic [IDX_W-1:0]            upd_set,
    input  logic [WAY_W-1:0]            upd_way,
    input  logic [TAG_W-1:0]            upd_tag,
    input  logic                        upd_rd,
    input  logic                        upd_wr,
    input  logic                        clr_bits,
    input  logic                        inv_written
);

    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    logic [WAYS-1:0]            val_q [SETS];
    logic [WAYS-1:0]            rd_q  [SETS];
    logic [WAYS-1:0]            wr_q  [SETS];

    // Read ports: both sets are read straight from the flops.
    always_comb begin
        a_tag   = tag_q[a_set];
        a_valid = val_q[a_set];
        a_rd    = rd_q[a_set];
        a_wr    = wr_q[a_set];
        b_tag   = tag_q[b_set];
        b_valid = val_q[b_set];
        b_rd    = rd_q[b_set];
        b_wr    = wr_q[b_set];
    end

    // State bits: reset, bulk clear at transaction end, or single-way update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                val_q[s] <= '0;
                rd_q[s]  <= '0;
                wr_q[s]  <= '0;
            end
        end else if (clr_bits) begin
            for (int s = 0; s < SETS; s++) begin
                rd_q[s] <= '0;
                wr_q[s] <= '0;
                if (inv_written) begin
                    val_q[s] <= val_q[s] & ~wr_q[s];
                end
            end
        end else if (upd_en) begin
            if (upd_alloc) begin
                val_q[upd_set][upd_way] <= 1'b1;
                rd_q[upd_set][upd_way]  <= upd_rd;
                wr_q[upd_set][upd_way]  <= upd_wr;
            end else begin
                rd_q[upd_set][upd_way]  <= rd_q[upd_set][upd_way] | upd_rd;
                wr_q[upd_set][upd_way]  <= wr_q[upd_set][upd_way] | upd_wr;
            end
        end
    end

    // Tag write on allocation; tags carry no reset.
    always_ff @(posedge clk) begin
        if (upd_en && upd_alloc && !clr_bits) begin
            tag_q[upd_set][upd_way] <= upd_tag;
        end
    end

endmodule

// File: rtl/trk_txn_ctrl.sv
// Module: trk_txn_ctrl
// Holds the transaction state (active, load tracking suspended, abort
// already issued). Decides whether an access updates the array, and turns
// conflict and overflow detections into a single registered abort pulse,
// conflict first. Assumes lookups are for the current-cycle access and
// snoop; commit or abort drops any access in the same cycle.
module trk_txn_ctrl
    import txn_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic txn_begin,
    input  logic txn_commit,
    input  logic txn_abort,
    input  logic trk_suspend,
    input  logic trk_resume,
    input  logic acc_valid,
    input  logic acc_write,
    input  logic acc_hit,
    input  logic acc_free_ok,
    input  logic snp_valid,
    input  logic snp_write,
    input  logic snp_hit,
    input  logic snp_line_rd,
    input  logic snp_line_wr,
    output logic upd_en,
    output logic upd_alloc,
    output logic upd_rd,
    output logic upd_wr,
    output logic clr_bits,
    output logic inv_written,
    output logic conflict_abort,
    output logic overflow_abort
);

    logic   act_q, susp_q, fired_q, cfl_q, ovf_q;
    logic   ending, live, counted, cfl_now, ovf_now;
    cause_e cause_d;

    // Classify this cycle's access and snoop against the transaction state.
    always_comb begin
        ending  = txn_commit | txn_abort;
        live    = act_q & ~fired_q & ~ending;
        counted = acc_valid & (acc_write | ~susp_q);
        cfl_now = live & snp_valid & snp_hit & (snp_line_wr | (snp_write & snp_line_rd));
        ovf_now = live & counted & ~acc_hit & ~acc_free_ok;
        if (cfl_now)      cause_d = CAUSE_CONFLICT;
        else if (ovf_now) cause_d = CAUSE_OVERFLOW;
        else              cause_d = CAUSE_NONE;
    end

    // Array update controls for a tracked access that fits.
    always_comb begin
        upd_en      = live & counted & (acc_hit | acc_free_ok);
        upd_alloc   = ~acc_hit;
        upd_rd      = ~acc_write;
        upd_wr      = acc_write;
        clr_bits    = ending;
        inv_written = txn_abort;
    end

    // Transaction state and registered abort pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            susp_q  <= 1'b0;
            fired_q <= 1'b0;
            cfl_q   <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            cfl_q <= (cause_d == CAUSE_CONFLICT);
            ovf_q <= (cause_d == CAUSE_OVERFLOW);
            if (ending)         act_q <= 1'b0;
            else if (txn_begin) act_q <= 1'b1;
            if (txn_begin)                   fired_q <= 1'b0;
            else if (cause_d != CAUSE_NONE)  fired_q <= 1'b1;
            if (ending || txn_begin || trk_resume) susp_q <= 1'b0;
            else if (trk_suspend && act_q)         susp_q <= 1'b1;
        end
    end

    assign conflict_abort = cfl_q;
    assign overflow_abort = ovf_q;

endmodule

// File: rtl/txn_set_tracker.sv
// Module: txn_set_tracker (top)
// Tracks the read and write sets of one transaction at line granularity
// in a set-associative tag array, and raises conflict or capacity abort
// pulses. Assumes one local access and one snoop per cycle at most.
module txn_set_tracker
    import txn_trk_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int OFF_W  = DEF_OFF_W,
    parameter int IDX_W  = DEF_IDX_W,
    parameter int WAYS   = DEF_WAYS,
    localparam int SETS  = 1 << IDX_W,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_begin,
    input  logic              txn_commit,
    input  logic              txn_abort,
    input  logic              trk_suspend,
    input  logic              trk_resume,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              conflict_abort,
    output logic              overflow_abort
);

    logic [IDX_W-1:0] a_set, b_set;
    logic [TAG_W-1:0] a_tagin, b_tagin;
    logic [WAYS-1:0][TAG_W-1:0] a_tag, b_tag;
    logic [WAYS-1:0]  a_valid, a_rd, a_wr, b_valid, b_rd, b_wr;
    logic             a_hit, a_free_ok, b_hit, b_free_unused;
    logic [WAY_W-1:0] a_hit_way, a_free_way, b_hit_way, b_free_way_unused;
    logic             upd_en, upd_alloc, upd_rd, upd_wr, clr_bits, inv_written;
    logic [WAY_W-1:0] upd_way;
    logic             snp_line_rd, snp_line_wr;
    logic             unused_offsets;

    // Address split into set index and tag.
    always_comb begin
        a_set   = acc_addr[OFF_W +: IDX_W];
        b_set   = snp_addr[OFF_W +: IDX_W];
        a_tagin = acc_addr[ADDR_W-1 -: TAG_W];
        b_tagin = snp_addr[ADDR_W-1 -: TAG_W];
        unused_offsets = ^{acc_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};
    end

    trk_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) i_array (
        .clk(clk), .rst_n(rst_n),
        .a_set(a_set), .a_tag(a_tag), .a_valid(a_valid), .a_rd(a_rd), .a_wr(a_wr),
        .b_set(b_set), .b_tag(b_tag), .b_valid(b_valid), .b_rd(b_rd), .b_wr(b_wr),
        .upd_en(upd_en), .upd_alloc(upd_alloc), .upd_set(a_set), .upd_way(upd_way),
        .upd_tag(a_tagin), .upd_rd(upd_rd), .upd_wr(upd_wr),
        .clr_bits(clr_bits), .inv_written(inv_written)
    );

    trk_way_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_acc_lookup (
        .tag_in(a_tagin), .way_tag(a_tag), .way_valid(a_valid), .way_rd(a_rd),
        .way_wr(a_wr), .hit(a_hit), .hit_way(a_hit_way),
        .free_ok(a_free_ok), .free_way(a_free_way)
    );

    trk_way_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_snp_lookup (
        .tag_in(b_tagin), .way_tag(b_tag), .way_valid(b_valid), .way_rd(b_rd),
        .way_wr(b_wr), .hit(b_hit), .hit_way(b_hit_way),
        .free_ok(b_free_unused), .free_way(b_free_way_unused)
    );

    // Update target way and the set bits of the snooped line.
    always_comb begin
        upd_way     = a_hit ? a_hit_way : a_free_way;
        snp_line_rd = b_rd[b_hit_way];
        snp_line_wr = b_wr[b_hit_way];
    end

    trk_txn_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .txn_begin(txn_begin), .txn_commit(txn_commit), .txn_abort(txn_abort),
        .trk_suspend(trk_suspend), .trk_resume(trk_resume),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_hit(a_hit), .acc_free_ok(a_free_ok),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_hit(b_hit),
        .snp_line_rd(snp_line_rd), .snp_line_wr(snp_line_wr),
        .upd_en(upd_en), .upd_alloc(upd_alloc), .upd_rd(upd_rd), .upd_wr(upd_wr),
        .clr_bits(clr_bits), .inv_written(inv_written),
        .conflict_abort(conflict_abort), .overflow_abort(overflow_abort)
    );

endmodule

// File: rtl/txn_set_tracker_chk.sv
// Module: txn_set_tracker_chk
// Port-level protocol checks for txn_set_tracker, attached by bind. Keeps
// its own view of "transaction active", "loads suspended" and "abort
// already seen", built only from the top-level ports.
module txn_set_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic txn_begin,
    input logic txn_commit,
    input logic txn_abort,
    input logic trk_suspend,
    input logic trk_resume,
    input logic acc_valid,
    input logic acc_write,
    input logic snp_valid,
    input logic conflict_abort,
    input logic overflow_abort
);

    logic act_m, susp_m, seen_m;

    // Shadow state derived from the port strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_m  <= 1'b0;
            susp_m <= 1'b0;
            seen_m <= 1'b0;
        end else begin
            if (txn_commit || txn_abort) act_m <= 1'b0;
            else if (txn_begin)          act_m <= 1'b1;
            if (txn_commit || txn_abort || txn_begin || trk_resume) susp_m <= 1'b0;
            else if (trk_suspend && act_m)                          susp_m <= 1'b1;
            if (txn_begin)                             seen_m <= 1'b0;
            else if (conflict_abort || overflow_abort) seen_m <= 1'b1;
        end
    end

    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(conflict_abort && overflow_abort)); // R11

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_m |-> !(conflict_abort || overflow_abort)); // R11

    AST_CONFLICT_FROM_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_abort |-> $past(snp_valid && act_m)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_abort || overflow_abort) |-> $past(act_m)); // R12

    AST_NO_SUSPENDED_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_abort |-> $past(acc_valid && (acc_write || !susp_m))); // R6

    AST_PULSE_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_abort |=> !overflow_abort); // R3

endmodule

bind txn_set_tracker txn_set_tracker_chk i_chk (
    .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_commit(txn_commit),
    .txn_abort(txn_abort), .trk_suspend(trk_suspend), .trk_resume(trk_resume),
    .acc_valid(acc_valid), .acc_write(acc_write), .snp_valid(snp_valid),
    .conflict_abort(conflict_abort), .overflow_abort(overflow_abort)
);

// File: tb/test_txn_set_tracker.sv
// Directed bench for txn_set_tracker: one task per scenario, each checking
// its own results at the falling edge after the sampling rising edge.
module test_txn_set_tracker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_begin = 0, txn_commit = 0, txn_abort = 0;
    logic        trk_suspend = 0, trk_resume = 0;
    logic        acc_valid = 0, acc_write = 0;
    logic [31:0] acc_addr = '0;
    logic        snp_valid = 0, snp_write = 0;
    logic [31:0] snp_addr = '0;
    logic        conflict_abort, overflow_abort;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    txn_set_tracker i_txn_set_tracker (
        .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_commit(txn_commit),
        .txn_abort(txn_abort), .trk_suspend(trk_suspend), .trk_resume(trk_resume),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .conflict_abort(conflict_abort), .overflow_abort(overflow_abort)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] line(input int tag, input int set, input int off);
        return {tag[19:0], set[5:0], off[5:0]};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Wait one rising edge, then land on the falling edge where results show.
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        {txn_begin, txn_commit, txn_abort, trk_suspend, trk_resume} = '0;
        {acc_valid, acc_write, snp_valid, snp_write} = '0;
    endtask

    task automatic t_begin();   txn_begin = 1;   cycle(); endtask
    task automatic t_commit();  txn_commit = 1;  cycle(); endtask
    task automatic t_abort();   txn_abort = 1;   cycle(); endtask
    task automatic t_suspend(); trk_suspend = 1; cycle(); endtask
    task automatic t_resume();  trk_resume = 1;  cycle(); endtask

    task automatic acc(input logic [31:0] a, input logic w, output logic c, output logic o);
        acc_valid = 1; acc_write = w; acc_addr = a;
        cycle();
        c = conflict_abort; o = overflow_abort;
    endtask

    task automatic snp(input logic [31:0] a, input logic w, output logic c, output logic o);
        snp_valid = 1; snp_write = w; snp_addr = a;
        cycle();
        c = conflict_abort; o = overflow_abort;
    endtask

    task automatic test_reset();
        chk("R1 conflict after reset", conflict_abort, 1'b0);
        chk("R1 overflow after reset", overflow_abort, 1'b0);
    endtask

    task automatic test_capacity();
        logic c, o;
        logic any = 0;
        t_begin();
        for (int i = 1; i <= 8; i++) begin
            acc(line(i, 5, 0), i[0], c, o);
            any |= c | o;
        end
        chk("R3 eight lines fit", any, 1'b0);
        acc(line(9, 5, 0), 1'b0, c, o);
        chk("R3 ninth line overflow", o, 1'b1);
        chk("R3 no conflict on overflow", c, 1'b0);
        acc(line(10, 5, 0), 1'b0, c, o);
        chk("R3 pulse one cycle / R11 ignored after", o, 1'b0);
        t_commit();
    endtask

    task automatic test_granule();
        logic c, o;
        logic any = 0;
        t_begin();
        for (int i = 1; i <= 8; i++) begin
            acc(line(i, 7, 0), 1'b0, c, o);
            any |= c | o;
        end
        acc(line(1, 7, 36), 1'b0, c, o);
        any |= c | o;
        chk("R2 same line takes no way", any, 1'b0);
        snp(line(3, 7, 16), 1'b1, c, o);
        chk("R2 R4 snoop other byte of read line", c, 1'b1);
        t_abort();
    endtask

    task automatic test_snoop_types();
        logic c, o;
        t_begin();
        acc(line(20, 11, 0), 1'b0, c, o);
        acc(line(21, 11, 0), 1'b1, c, o);
        snp(line(20, 11, 0), 1'b0, c, o);
        chk("R5 read snoop on read-set line ignored", c, 1'b0);
        snp(line(21, 11, 8), 1'b0, c, o);
        chk("R5 read snoop on write-set line", c, 1'b1);
        t_abort();
        t_begin();
        acc(line(22, 12, 0), 1'b0, c, o);
        snp(line(22, 12, 0), 1'b1, c, o);
        chk("R4 write snoop on read-set line", c, 1'b1);
        t_abort();
        t_begin();
        acc(line(23, 12, 0), 1'b1, c, o);
        snp(line(23, 12, 0), 1'b1, c, o);
        chk("R4 write snoop on write-set line", c, 1'b1);
        t_abort();
    endtask

    task automatic test_suspend();
        logic c, o;
        logic any = 0;
        t_begin();
        acc(line(30, 13, 0), 1'b0, c, o);
        t_suspend();
        acc(line(31, 13, 0), 1'b0, c, o);
        snp(line(31, 13, 0), 1'b1, c, o);
        chk("R6 suspended load not in read set", c, 1'b0);
        snp(line(30, 13, 0), 1'b1, c, o);
        chk("R7 earlier line conflicts while suspended", c, 1'b1);
        t_abort();
        t_begin();
        t_suspend();
        acc(line(32, 14, 0), 1'b1, c, o);
        snp(line(32, 14, 0), 1'b0, c, o);
        chk("R7 store tracked while suspended", c, 1'b1);
        t_abort();
        t_begin();
        t_suspend();
        for (int i = 40; i < 50; i++) begin
            acc(line(i, 15, 0), 1'b0, c, o);
            any |= o;
        end
        chk("R6 suspended loads take no way", any, 1'b0);
        t_resume();
        acc(line(51, 15, 0), 1'b0, c, o);
        snp(line(51, 15, 0), 1'b1, c, o);
        chk("R8 resume restores load tracking", c, 1'b1);
        t_abort();
    endtask

    task automatic test_clear();
        logic c, o;
        logic any = 0;
        t_begin();
        for (int i = 60; i < 68; i++) acc(line(i, 16, 0), 1'b1, c, o);
        t_commit();
        t_begin();
        snp(line(60, 16, 0), 1'b1, c, o);
        chk("R9 commit clears write set", c, 1'b0);
        for (int i = 70; i < 78; i++) begin
            acc(line(i, 16, 0), 1'b0, c, o);
            any |= o;
        end
        chk("R9 ways free after commit", any, 1'b0);
        t_abort();
        t_begin();
        snp(line(72, 16, 0), 1'b1, c, o);
        chk("R9 abort clears read set", c, 1'b0);
        t_commit();
    endtask

    task automatic test_outside();
        logic c, o;
        acc(line(80, 17, 0), 1'b1, c, o);
        snp(line(80, 17, 0), 1'b1, c, o);
        chk("R12 idle access not tracked / snoop quiet", c, 1'b0);
        t_suspend();
        t_begin();
        acc(line(81, 17, 0), 1'b0, c, o);
        snp(line(81, 17, 0), 1'b1, c, o);
        chk("R10 idle suspend has no effect", c, 1'b1);
        t_abort();
    endtask

    task automatic test_first_wins();
        logic c, o;
        t_begin();
        for (int i = 1; i <= 8; i++) acc(line(90 + i, 9, 0), 1'b0, c, o);
        acc_valid = 1; acc_write = 0; acc_addr = line(99, 9, 0);
        snp_valid = 1; snp_write = 1; snp_addr = line(91, 9, 0);
        cycle();
        chk("R11 conflict wins same cycle", conflict_abort, 1'b1);
        chk("R11 overflow suppressed", overflow_abort, 1'b0);
        snp(line(92, 9, 0), 1'b1, c, o);
        chk("R11 later snoop ignored", c, 1'b0);
        t_abort();
        t_begin();
        acc(line(93, 9, 0), 1'b0, c, o);
        snp(line(93, 9, 0), 1'b1, c, o);
        chk("R11 new begin re-arms", c, 1'b1);
        t_abort();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        test_reset();
        test_capacity();
        test_granule();
        test_snoop_types();
        test_suspend();
        test_clear();
        test_outside();
        test_first_wins();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule